// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive-side descriptor engine of a DMA Ethernet MAC. It owns a small internal RAM of descriptors. Each entry holds a 16-bit status word, a 16-bit length word and a 32-bit buffer pointer. Software prepares entries through a word-wide access port. It marks an entry as handed to hardware by setting its ownership bit. The engine then consumes one entry per incoming frame. Frame payload is not stored. Each byte beat only advances the frame length counter.

The engine examines the entry at the current index. When hardware owns the entry, the next frame is accepted. At the end of the frame the engine writes back the byte count, including the 4-byte check sequence, and the error bits. It then returns the entry to software and moves to the next index. A per-entry wrap flag closes the ring. When the engine finds an entry that software still owns, it parks in a halted state and raises a sticky busy event until software issues a resume. A level stop request lets the frame in progress finish and then holds the engine idle. While the engine cannot take a frame, any frame that starts is dropped and counted.

Top module: `rx_desc_ring`

## Requirements
- R1: While reset is asserted, `curIdx`, `halted`, `busyEvt`, `stopDone` and `dropCnt` are zero. Every descriptor field clears to zero, which means software owns every entry. The first fetch after reset therefore halts and raises `busyEvt`.
- R2: Bit 15 of the status word set to 1 marks an entry as owned by hardware. A frame that starts while the engine is armed on such an entry is accepted. Its length field is then written with the number of beats in the frame, from the first beat to the last. The buffer pointer field is never modified by the engine.
- R3: At writeback the engine clears status bit 15 and keeps status bits 14:8, including the wrap bit at bit 13. It rewrites bits 7:0 as error flags:
  - bit 0 is set when `rxErr` was high on the last beat;
  - bit 1 is set when the length exceeds MAX_LEN.
  A frame is good when bits 7:0 are zero. A frame of exactly MAX_LEN beats is good.
- R4: After writeback the index moves to 0 if the consumed entry had status bit 13 set, or if it was the last physical entry. Otherwise the index increments by one.
- R5: When the entry at the current index has status bit 15 clear, the engine enters the halted state (`halted`=1) and sets `busyEvt`.
- R6: A `clearHalt` pulse makes the engine fetch the current entry again. `busyEvt` stays set until a `busyClr` pulse clears it. A new busy condition in the same cycle as `busyClr` wins.
- R7: When `stopReq` goes high during a frame, that frame completes with full writeback and index advance. The engine then sets `stopDone` and accepts no frames until `stopReq` falls, after which it fetches again.
- R8: A `ringRestart` pulse resets the index to 0. It has no effect while a frame is being received or written back.
- R9: A frame whose first beat arrives while the engine is not armed (halted, stopped, fetching or writing back) is dropped. `dropCnt` increments by one and no descriptor changes.
- R10: The software port addresses `{index, field}`, with field 0 = status, 1 = length, 2 = pointer and 3 = none. `swRdata` returns the addressed field one clock after the address is presented. Field 3 reads as zero. `swWe` writes the field. Status and length take `swWdata[15:0]`.
- R11: A software write to the descriptor that the engine writes back in the same cycle is discarded; the engine's values remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxValid | input | 1 | Frame byte beat present |
| rxLast | input | 1 | Beat is the last of its frame |
| rxErr | input | 1 | Frame error, sampled on the last beat |
| stopReq | input | 1 | Graceful stop request (level) |
| clearHalt | input | 1 | Resume pulse after a halt |
| busyClr | input | 1 | Clears the busy event |
| ringRestart | input | 1 | Resets the ring index to 0 |
| swWe | input | 1 | Software write enable |
| swAddr | input | IDX_W+2 | Software address {index, field} |
| swWdata | input | 32 | Software write data |
| swRdata | output | 32 | Software read data, one cycle latency |
| curIdx | output | IDX_W | Current ring index |
| halted | output | 1 | Engine halted on a software-owned entry |
| busyEvt | output | 1 | Sticky busy event |
| stopDone | output | 1 | Graceful stop complete |
| dropCnt | output | CNT_W | Dropped frame count |

## Verification
The assertions assume the following about the inputs:
- `rxLast` and `rxErr` only matter when `rxValid` is high.
- Frames never overlap.
- Software does not rewrite the entry under the current index while the engine is armed on it, except in the deliberate collision case.

The stimulus keeps to these rules. It drives whole frames from one task, separated by idle gaps of several cycles. It changes descriptors only while the engine is halted, with one exception: the collision test, which times a status write into the exact writeback cycle. Control pulses last one cycle, and frames start only once the engine has had two clocks to re-fetch.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int FIELD_W   = 16;
  localparam int PTR_W     = 32;
  localparam int BIT_OWN   = 15;
  localparam int BIT_WRAP  = 13;
  localparam int BIT_BAD   = 0;
  localparam int BIT_LONG  = 1;

  typedef enum logic [2:0] {
    ST_FETCH, ST_ARMED, ST_RECV, ST_WBACK, ST_HALT, ST_STOP
  } ringState_t;

  typedef enum logic [1:0] {
    FLD_STAT = 2'd0, FLD_LEN = 2'd1, FLD_PTR = 2'd2, FLD_NONE = 2'd3
  } descField_t;

  typedef struct packed {
    logic beatFirst;
    logic beatNext;
    logic wback;
    logic idxClr;
    logic dropInc;
  } ringStb_t;
endpackage

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxValid,
  input  logic     rxLast,
  input  logic     stopReq,
  input  logic     clearHalt,
  input  logic     busyClr,
  input  logic     ringRestart,
  input  logic     curEmpty,
  output ringStb_t stb,
  output logic     halted,
  output logic     busyEvt,
  output logic     stopDone
);
  ringState_t state, nextState;
  logic inFrame, sop, accept, busySet;

  assign sop = rxValid && !inFrame;

  always_comb begin
    nextState = state;
    stb       = '0;
    accept    = 1'b0;
    busySet   = 1'b0;
    unique case (state)
      ST_FETCH: begin
        if (stopReq)          nextState = ST_STOP;
        else if (ringRestart) stb.idxClr = 1'b1;
        else if (curEmpty)    nextState = ST_ARMED;
        else begin
          nextState = ST_HALT;
          busySet   = 1'b1;
        end
      end
      ST_ARMED: begin
        if (stopReq) nextState = ST_STOP;
        else if (ringRestart) begin
          stb.idxClr = 1'b1;
          nextState  = ST_FETCH;
        end else if (sop) begin
          accept        = 1'b1;
          stb.beatFirst = 1'b1;
          nextState     = rxLast ? ST_WBACK : ST_RECV;
        end
      end
      ST_RECV: begin
        if (rxValid) begin
          stb.beatNext = 1'b1;
          if (rxLast) nextState = ST_WBACK;
        end
      end
      ST_WBACK: begin
        stb.wback = 1'b1;
        nextState = stopReq ? ST_STOP : ST_FETCH;
      end
      ST_HALT: begin
        stb.idxClr = ringRestart;
        if (clearHalt)    nextState = ST_FETCH;
        else if (stopReq) nextState = ST_STOP;
      end
      ST_STOP: begin
        stb.idxClr = ringRestart;
        if (!stopReq) nextState = ST_FETCH;
      end
      default: nextState = ST_FETCH;
    endcase
    stb.dropInc = sop && !accept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_FETCH;
      inFrame <= 1'b0;
      busyEvt <= 1'b0;
    end else begin
      state <= nextState;
      if (rxValid) inFrame <= !rxLast;
      if (busySet)      busyEvt <= 1'b1;
      else if (busyClr) busyEvt <= 1'b0;
    end
  end

  assign halted   = (state == ST_HALT);
  assign stopDone = (state == ST_STOP);

  // R5: entering the halted state always comes with the busy event
  a_r5_busy_on_halt: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halted) |-> busyEvt);
  // R6: without a resume or a stop, a halt persists
  a_r6_halt_holds: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !clearHalt && !stopReq) |=> halted);
  // R7: a stop seen at writeback leads straight to the stopped state
  a_r7_stop_after_frame: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wback && stopReq) |=> stopDone);
  // R7: no frame is taken while stopped
  a_r7_no_accept_stopped: assert property (@(posedge clk) disable iff (!rstN)
    stopDone |-> !stb.beatFirst);
endmodule

// File: rtl/rxring_dpath.sv
module rxring_dpath
  import rxring_pkg::*;
#(
  parameter int DESC_COUNT = 8,
  parameter int MAX_LEN    = 1518,
  parameter int CNT_W      = 16,
  localparam int IDX_W     = $clog2(DESC_COUNT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ringStb_t           stb,
  input  logic               rxLast,
  input  logic               rxErr,
  input  logic               swWe,
  input  logic [IDX_W+1:0]   swAddr,
  input  logic [PTR_W-1:0]   swWdata,
  output logic [PTR_W-1:0]   swRdata,
  output logic               curEmpty,
  output logic [IDX_W-1:0]   curIdx,
  output logic [CNT_W-1:0]   dropCnt
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_COUNT - 1);

  logic [FIELD_W-1:0] statMem [DESC_COUNT];
  logic [FIELD_W-1:0] lenMem  [DESC_COUNT];
  logic [PTR_W-1:0]   ptrMem  [DESC_COUNT];

  logic [FIELD_W-1:0] frmLen;
  logic               errLat;
  logic               curWrap;
  logic [FIELD_W-1:0] hwStat;
  logic [IDX_W-1:0]   swIdx, nextIdx;
  descField_t         swFld;
  logic               swBlocked;

  assign swIdx    = swAddr[IDX_W+1:2];
  assign swFld    = descField_t'(swAddr[1:0]);
  assign curEmpty = statMem[curIdx][BIT_OWN];
  assign curWrap  = statMem[curIdx][BIT_WRAP];

  always_comb begin
    hwStat                    = '0;
    hwStat[BIT_OWN-1:8]       = statMem[curIdx][BIT_OWN-1:8];
    hwStat[BIT_BAD]           = errLat;
    hwStat[BIT_LONG]          = (frmLen > FIELD_W'(MAX_LEN));
  end

  assign nextIdx   = (curWrap || curIdx == LAST_IDX) ? '0 : curIdx + 1'b1;
  assign swBlocked = stb.wback && (swIdx == curIdx);

  // frame length and error capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frmLen <= '0;
      errLat <= 1'b0;
    end else if (stb.beatFirst) begin
      frmLen <= FIELD_W'(1);
      errLat <= rxLast && rxErr;
    end else if (stb.beatNext) begin
      if (frmLen != '1) frmLen <= frmLen + 1'b1;
      if (rxLast) errLat <= rxErr;
    end
  end

  // ring index and drop counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx  <= '0;
      dropCnt <= '0;
    end else begin
      if (stb.idxClr)     curIdx <= '0;
      else if (stb.wback) curIdx <= nextIdx;
      if (stb.dropInc) dropCnt <= dropCnt + 1'b1;
    end
  end

  // descriptor RAM: engine writes win over software
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DESC_COUNT; i++) begin
        statMem[i] <= '0;
        lenMem[i]  <= '0;
        ptrMem[i]  <= '0;
      end
    end else begin
      if (swWe && !swBlocked) begin
        unique case (swFld)
          FLD_STAT: statMem[swIdx] <= swWdata[FIELD_W-1:0];
          FLD_LEN:  lenMem[swIdx]  <= swWdata[FIELD_W-1:0];
          FLD_PTR:  ptrMem[swIdx]  <= swWdata;
          default:  ;
        endcase
      end
      if (stb.wback) begin
        statMem[curIdx] <= hwStat;
        lenMem[curIdx]  <= frmLen;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) swRdata <= '0;
    else begin
      unique case (swFld)
        FLD_STAT: swRdata <= PTR_W'(statMem[swIdx]);
        FLD_LEN:  swRdata <= PTR_W'(lenMem[swIdx]);
        FLD_PTR:  swRdata <= ptrMem[swIdx];
        default:  swRdata <= '0;
      endcase
    end
  end

  // R3, R11: after writeback the entry belongs to software
  a_r3_own_released: assert property (@(posedge clk) disable iff (!rstN)
    stb.wback |=> !statMem[$past(curIdx)][BIT_OWN]);
  // R4: plain step to the following entry
  a_r4_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wback && !curWrap && curIdx != LAST_IDX) |=> curIdx == IDX_W'($past(curIdx) + 1'b1));
  // R4: wrap flag returns the index to 0
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wback && curWrap) |=> curIdx == '0);
  // R9: each dropped frame counts once
  a_r9_drop_count: assert property (@(posedge clk) disable iff (!rstN)
    stb.dropInc |=> dropCnt == CNT_W'($past(dropCnt) + 1'b1));
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
  import rxring_pkg::*;
#(
  parameter int DESC_COUNT = 8,
  parameter int MAX_LEN    = 1518,
  parameter int CNT_W      = 16,
  localparam int IDX_W     = $clog2(DESC_COUNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic             rxLast,
  input  logic             rxErr,
  input  logic             stopReq,
  input  logic             clearHalt,
  input  logic             busyClr,
  input  logic             ringRestart,
  input  logic             swWe,
  input  logic [IDX_W+1:0] swAddr,
  input  logic [31:0]      swWdata,
  output logic [31:0]      swRdata,
  output logic [IDX_W-1:0] curIdx,
  output logic             halted,
  output logic             busyEvt,
  output logic             stopDone,
  output logic [CNT_W-1:0] dropCnt
);
  ringStb_t stb;
  logic     curEmpty;

  rxring_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxLast(rxLast),
    .stopReq(stopReq), .clearHalt(clearHalt), .busyClr(busyClr),
    .ringRestart(ringRestart), .curEmpty(curEmpty), .stb(stb),
    .halted(halted), .busyEvt(busyEvt), .stopDone(stopDone)
  );

  rxring_dpath #(.DESC_COUNT(DESC_COUNT), .MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rxLast(rxLast), .rxErr(rxErr),
    .swWe(swWe), .swAddr(swAddr), .swWdata(swWdata), .swRdata(swRdata),
    .curEmpty(curEmpty), .curIdx(curIdx), .dropCnt(dropCnt)
  );
endmodule

// File: tb/rx_desc_ring_tb_top.sv
`timescale 1ns/1ps
module rx_desc_ring_tb_top;
  localparam int IDX_W = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic rxValid = 0, rxLast = 0, rxErr = 0, stopReq = 0;
  logic clearHalt = 0, busyClr = 0, ringRestart = 0, swWe = 0;
  logic [IDX_W+1:0] swAddr = '0;
  logic [31:0] swWdata = '0, swRdata;
  logic [IDX_W-1:0] curIdx;
  logic halted, busyEvt, stopDone;
  logic [15:0] dropCnt;

  int nChecks = 0, nFails = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  rx_desc_ring dut_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxLast(rxLast), .rxErr(rxErr),
    .stopReq(stopReq), .clearHalt(clearHalt), .busyClr(busyClr),
    .ringRestart(ringRestart), .swWe(swWe), .swAddr(swAddr), .swWdata(swWdata),
    .swRdata(swRdata), .curIdx(curIdx), .halted(halted), .busyEvt(busyEvt),
    .stopDone(stopDone), .dropCnt(dropCnt)
  );

  // {frame beats, error flag, expected status word}
  localparam logic [39:0] VEC [4] = '{
    {16'd64,  8'd0, 16'h0000},
    {16'd5,   8'd1, 16'h0001},
    {16'd1,   8'd0, 16'h0000},
    {16'd100, 8'd1, 16'h2001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic swWrite(input int idx, input int fld, input logic [31:0] d);
    swWe = 1'b1; swAddr = {IDX_W'(idx), 2'(fld)}; swWdata = d;
    @(negedge clk);
    swWe = 1'b0;
  endtask

  task automatic swRead(input int idx, input int fld, output logic [31:0] d);
    swAddr = {IDX_W'(idx), 2'(fld)};
    @(negedge clk);
    d = swRdata;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendFrame(input int n, input bit err, input int stopAt, input bit collide);
    for (int b = 0; b < n; b++) begin
      rxValid = 1'b1;
      rxLast  = (b == n - 1);
      rxErr   = err && (b == n - 1);
      if (b == stopAt) stopReq = 1'b1;
      @(negedge clk);
    end
    rxValid = 0; rxLast = 0; rxErr = 0;
    if (collide) begin
      swWe = 1'b1; swAddr = {IDX_W'(0), 2'd0}; swWdata = 32'h0000_ABCD;
      @(negedge clk);
      swWe = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    check("R1 curIdx", 32'(curIdx), 0);
    check("R1 halted", 32'(halted), 0);
    check("R1 busy", 32'(busyEvt), 0);
    check("R1 stopDone", 32'(stopDone), 0);
    check("R1 dropCnt", 32'(dropCnt), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    swRead(2, 0, rd); check("R1 status cleared", rd, 0);
    check("R1 first fetch halts", 32'(halted), 1);
    check("R1 first fetch busy", 32'(busyEvt), 1);
    pulse(busyClr);
    check("R6 busy cleared", 32'(busyEvt), 0);

    // prepare ring 0..3, entry 3 wraps
    swWrite(0, 2, 32'h1000_0000);
    swWrite(0, 0, 32'h8000);
    swWrite(1, 0, 32'h8000);
    swWrite(2, 0, 32'h8000);
    swWrite(3, 0, 32'hA000);
    pulse(clearHalt);
    check("R6 resumed", 32'(halted), 0);

    for (int v = 0; v < 4; v++) begin
      sendFrame(int'(VEC[v][39:24]), VEC[v][16], -1, 1'b0);
      swRead(v, 0, rd); check("R3 status", rd, 32'(VEC[v][15:0]));
      swRead(v, 1, rd); check("R2 length", rd, 32'(VEC[v][39:24]));
      check("R4 index", 32'(curIdx), (v + 1) % 4);
    end
    swRead(0, 2, rd); check("R2 pointer kept", rd, 32'h1000_0000);
    check("R5 halted", 32'(halted), 1);
    check("R5 busy", 32'(busyEvt), 1);

    // R9: drop while halted
    sendFrame(7, 1'b0, -1, 1'b0);
    check("R9 dropCnt", 32'(dropCnt), 1);
    swRead(0, 1, rd); check("R9 length untouched", rd, 64);
    swRead(0, 0, rd); check("R9 status untouched", rd, 0);
    pulse(busyClr);
    check("R6 busy clear while halted", 32'(busyEvt), 0);
    check("R6 still halted", 32'(halted), 1);

    // R3: oversize frame
    swWrite(0, 0, 32'h8000);
    pulse(clearHalt);
    sendFrame(1519, 1'b0, -1, 1'b0);
    swRead(0, 0, rd); check("R3 oversize flag", rd, 32'h0002);
    swRead(0, 1, rd); check("R2 long length", rd, 1519);
    check("R5 halt on entry 1", 32'(halted), 1);

    // R7: stop during a frame of exactly MAX_LEN beats
    swWrite(1, 0, 32'h8000);
    pulse(busyClr);
    pulse(clearHalt);
    sendFrame(1518, 1'b0, 10, 1'b0);
    swRead(1, 0, rd); check("R3 boundary good", rd, 32'h0000);
    swRead(1, 1, rd); check("R7 frame finished", rd, 1518);
    check("R7 stopDone", 32'(stopDone), 1);
    check("R7 index advanced", 32'(curIdx), 2);
    sendFrame(4, 1'b0, -1, 1'b0);
    check("R7 dropped while stopped", 32'(dropCnt), 2);
    stopReq = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 stop released", 32'(stopDone), 0);
    check("R5 halt on entry 2", 32'(halted), 1);
    check("R6 busy set again", 32'(busyEvt), 1);

    // R8: restart index
    pulse(ringRestart);
    check("R8 index zero", 32'(curIdx), 0);

    // R11: collision on writeback
    swWrite(0, 0, 32'h8000);
    pulse(clearHalt);
    sendFrame(3, 1'b0, -1, 1'b1);
    swRead(0, 0, rd); check("R11 engine wins status", rd, 32'h0000);
    swRead(0, 1, rd); check("R11 length", rd, 3);
    check("R4 index after collide", 32'(curIdx), 1);

    // R10: software port fields
    swWrite(5, 1, 32'h0000_1234);
    swRead(5, 1, rd); check("R10 length rw", rd, 32'h1234);
    swWrite(5, 3, 32'hFFFF_FFFF);
    swRead(5, 3, rd); check("R10 field 3 zero", rd, 0);
    swRead(5, 0, rd); check("R10 status untouched", rd, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule